// File: doc/BRIEF.md
# Switch port-group destination resolver

This block decides where one received frame goes in a small Ethernet switch with twelve front ports and one CPU port. It keeps a table of 13-bit port masks with a 3-bit CPU queue field per entry, loaded by software through a single-cycle write port. For each lookup it takes the ingress port, whether the address table produced a hit, the hit's entry type and destination index, and the frame class used for flooding. It returns the set of front ports to forward to, a CPU-copy flag and the CPU extraction queue.

The forwarding set is the AND of a destination mask, an aggregation mask (held at all ones here) and the ingress port's source mask. A frame that hits the address table with type 0 or 1, and whose destination mask names the CPU, is copied to the CPU even if the source mask leaves the CPU out. A frame that misses the table is flooded and reaches the CPU only through the normal three-way AND. Table layout: entries 0..11 are per-port unicast masks, 12..63 are multicast masks, 59 is the fixed CPU-only set, 60/61/62 are the unicast, multicast and broadcast flood masks, and 80+i is the source mask of ingress port i. Mask bit j (0..11) is front port j and bit 12 is the CPU.

Top module: `pgr_resolver`

## Requirements
- R1: After reset all outputs are zero, entry i (0..11) holds only bit i, entry 59 holds only bit 12, and every other entry mask and every queue field is zero.
- R2: A lookup presented with req_valid_i high yields its result, with res_valid_o high, on the cycle after the next clock edge; in any cycle with no result, res_valid_o, fwd_mask_o, cpu_copy_o and cpu_queue_o are all zero.
- R3: On a hit the destination mask is entry hit_idx_i, and fwd_mask_o bit j is set only when bit j is set in both that entry and source entry 80 + src_port_i.
- R4: On a miss the destination entry is chosen by frame_cls_i: 0 (unicast) selects entry 60, 1 (multicast) selects entry 61, 2 (broadcast) and 3 select entry 62.
- R5: Bit j of source entry 80+i set permits ingress port i to forward to port j; a cleared bit removes port j from the result.
- R6: The ingress port's own bit is never set in fwd_mask_o.
- R7: A hit with hit_type_i of 0 or 1 whose destination mask has bit 12 set raises cpu_copy_o whatever the source mask holds.
- R8: A flooded frame, or a hit with hit_type_i of 2 or 3, raises cpu_copy_o only when bit 12 is set in both the destination entry and the source entry.
- R9: cpu_queue_o equals the queue field of the destination entry used when cpu_copy_o is high, and is zero otherwise.
- R10: A write to entry 59 updates only its queue field; its mask stays bit 12 alone.
- R11: A write in the same cycle as a lookup is not seen by that lookup and is seen by the next one.
- R12: A src_port_i of 12 or more has an empty source mask: fwd_mask_o is zero and the CPU is reached only through the R7 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 7 | Table entry to write (0..95 stored, others dropped) |
| wr_mask_i | input | 13 | Port mask to store, bit 12 is the CPU |
| wr_queue_i | input | 3 | CPU queue to store with the mask |
| req_valid_i | input | 1 | Lookup strobe |
| src_port_i | input | 4 | Ingress port number |
| hit_i | input | 1 | Address table hit |
| hit_type_i | input | 2 | Entry type of the hit |
| hit_idx_i | input | 6 | Destination index carried by the hit |
| frame_cls_i | input | 2 | Flood class: 0 unicast, 1 multicast, 2/3 broadcast |
| res_valid_o | output | 1 | Result valid |
| fwd_mask_o | output | 12 | Front ports to forward to |
| cpu_copy_o | output | 1 | Copy the frame to the CPU |
| cpu_queue_o | output | 3 | CPU extraction queue |

## Verification
A corrupted table entry or a wrong index choice stays invisible until a lookup reads that entry, and then shows in the result one cycle after the strobe as a wrong front-port bit, a missing or spurious CPU copy, or a wrong queue. The bench therefore follows every write with lookups that read the written entry through both hit and flood paths and from several ingress ports. A mix-up between the CPU bypass and the source-mask path only shows for frames whose source mask leaves the CPU out, so those cases are run for both hit types and for floods.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  localparam int NUM_FRONT = 12;
  localparam int MASK_W    = NUM_FRONT + 1;
  localparam int CPU_BIT   = NUM_FRONT;
  localparam int Q_W       = 3;
  localparam int TBL_DEPTH = 96;
  localparam int IDX_W     = $clog2(TBL_DEPTH);
  localparam int DST_IDX_W = 6;
  localparam int PORT_W    = 4;
  localparam int TYPE_W    = 2;
  localparam int SRC_BASE  = 80;
  localparam int CPU_SET   = 59;
  localparam int UC_FLOOD  = 60;
  localparam int MC_FLOOD  = 61;
  localparam int BC_FLOOD  = 62;

  typedef enum logic [1:0] {
    CLS_UC  = 2'd0,
    CLS_MC  = 2'd1,
    CLS_BC  = 2'd2,
    CLS_RSV = 2'd3
  } frame_cls_e;

  typedef logic [MASK_W-1:0] pmask_t;

  typedef struct packed {
    pmask_t         mask;
    logic [Q_W-1:0] queue;
  } pg_entry_t;
endpackage

// File: rtl/pgr_table.sv
module pgr_table
  import pgr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  pmask_t           wr_mask_i,
  input  logic [Q_W-1:0]   wr_queue_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  input  logic [IDX_W-1:0] src_idx_i,
  output pg_entry_t        dst_ent_o,
  output pmask_t           src_mask_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TBL_DEPTH - 1);
  localparam logic [IDX_W-1:0] LOCK_IDX = IDX_W'(CPU_SET);

  pg_entry_t ent_q [TBL_DEPTH];

  function automatic pg_entry_t rst_ent(int i);
    pg_entry_t e;
    e.queue = '0;
    if (i < NUM_FRONT)     e.mask = pmask_t'(1) << i;
    else if (i == CPU_SET) e.mask = pmask_t'(1) << CPU_BIT;
    else                   e.mask = '0;
    return e;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TBL_DEPTH; i++) ent_q[i] <= rst_ent(i);
    end else if (wr_en_i && wr_idx_i <= LAST_IDX) begin
      if (wr_idx_i == LOCK_IDX) ent_q[CPU_SET].queue <= wr_queue_i;
      else                      ent_q[wr_idx_i] <= '{mask: wr_mask_i, queue: wr_queue_i};
    end
  end

  always_comb begin
    dst_ent_o  = (dst_idx_i <= LAST_IDX) ? ent_q[dst_idx_i] : '0;
    src_mask_o = (src_idx_i <= LAST_IDX) ? ent_q[src_idx_i].mask : '0;
  end
endmodule

// File: rtl/pgr_select.sv
module pgr_select
  import pgr_pkg::*;
(
  input  logic                 hit_i,
  input  logic [DST_IDX_W-1:0] hit_idx_i,
  input  logic [1:0]           frame_cls_i,
  input  logic [PORT_W-1:0]    src_port_i,
  output logic [IDX_W-1:0]     dst_idx_o,
  output logic [IDX_W-1:0]     src_idx_o,
  output logic                 src_ok_o
);
  frame_cls_e cls;
  logic [IDX_W-1:0] flood_idx;

  always_comb begin
    cls = frame_cls_e'(frame_cls_i);
    unique case (cls)
      CLS_UC:  flood_idx = IDX_W'(UC_FLOOD);
      CLS_MC:  flood_idx = IDX_W'(MC_FLOOD);
      default: flood_idx = IDX_W'(BC_FLOOD);
    endcase
    dst_idx_o = hit_i ? IDX_W'(hit_idx_i) : flood_idx;
    src_ok_o  = src_port_i < PORT_W'(NUM_FRONT);
    src_idx_o = src_ok_o ? IDX_W'(SRC_BASE) + IDX_W'(src_port_i) : IDX_W'(SRC_BASE);
  end
endmodule

// File: rtl/pgr_combine.sv
module pgr_combine
  import pgr_pkg::*;
(
  input  pg_entry_t             dst_ent_i,
  input  pmask_t                src_mask_i,
  input  logic                  src_ok_i,
  input  logic [PORT_W-1:0]     src_port_i,
  input  logic                  hit_i,
  input  logic [TYPE_W-1:0]     hit_type_i,
  output logic [NUM_FRONT-1:0]  fwd_o,
  output logic                  cpu_copy_o,
  output logic [Q_W-1:0]        cpu_queue_o
);
  pmask_t agg_mask;
  pmask_t src_eff;
  pmask_t all_mask;
  logic   bypass;

  always_comb begin
    agg_mask = '1;
    src_eff  = src_ok_i ? src_mask_i : '0;
    all_mask = dst_ent_i.mask & agg_mask & src_eff;
    // table-hit copy to CPU ignores the source mask
    bypass      = hit_i && (hit_type_i < TYPE_W'(2)) && dst_ent_i.mask[CPU_BIT];
    cpu_copy_o  = all_mask[CPU_BIT] | bypass;
    cpu_queue_o = cpu_copy_o ? dst_ent_i.queue : '0;
  end

  for (genvar g = 0; g < NUM_FRONT; g++) begin : g_port
    assign fwd_o[g] = all_mask[g] & ~(src_ok_i && src_port_i == PORT_W'(g));
  end
endmodule

// File: rtl/pgr_resolver.sv
module pgr_resolver
  import pgr_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [MASK_W-1:0]     wr_mask_i,
  input  logic [Q_W-1:0]        wr_queue_i,
  input  logic                  req_valid_i,
  input  logic [PORT_W-1:0]     src_port_i,
  input  logic                  hit_i,
  input  logic [TYPE_W-1:0]     hit_type_i,
  input  logic [DST_IDX_W-1:0]  hit_idx_i,
  input  logic [1:0]            frame_cls_i,
  output logic                  res_valid_o,
  output logic [NUM_FRONT-1:0]  fwd_mask_o,
  output logic                  cpu_copy_o,
  output logic [Q_W-1:0]        cpu_queue_o
);
  logic [IDX_W-1:0]     dst_idx;
  logic [IDX_W-1:0]     src_idx;
  logic                 src_ok;
  pg_entry_t            dst_ent;
  pmask_t               src_mask;
  logic [NUM_FRONT-1:0] fwd_d;
  logic                 copy_d;
  logic [Q_W-1:0]       queue_d;
  logic                 dst_cpu_w;

  pgr_select u_sel (
    .hit_i       (hit_i),
    .hit_idx_i   (hit_idx_i),
    .frame_cls_i (frame_cls_i),
    .src_port_i  (src_port_i),
    .dst_idx_o   (dst_idx),
    .src_idx_o   (src_idx),
    .src_ok_o    (src_ok)
  );

  pgr_table u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_mask_i  (wr_mask_i),
    .wr_queue_i (wr_queue_i),
    .dst_idx_i  (dst_idx),
    .src_idx_i  (src_idx),
    .dst_ent_o  (dst_ent),
    .src_mask_o (src_mask)
  );

  pgr_combine u_cmb (
    .dst_ent_i   (dst_ent),
    .src_mask_i  (src_mask),
    .src_ok_i    (src_ok),
    .src_port_i  (src_port_i),
    .hit_i       (hit_i),
    .hit_type_i  (hit_type_i),
    .fwd_o       (fwd_d),
    .cpu_copy_o  (copy_d),
    .cpu_queue_o (queue_d)
  );

  assign dst_cpu_w = dst_ent.mask[CPU_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      fwd_mask_o  <= '0;
      cpu_copy_o  <= 1'b0;
      cpu_queue_o <= '0;
    end else if (req_valid_i) begin
      res_valid_o <= 1'b1;
      fwd_mask_o  <= fwd_d;
      cpu_copy_o  <= copy_d;
      cpu_queue_o <= queue_d;
    end else begin
      res_valid_o <= 1'b0;
      fwd_mask_o  <= '0;
      cpu_copy_o  <= 1'b0;
      cpu_queue_o <= '0;
    end
  end
endmodule

// File: rtl/pgr_resolver_chk.sv
module pgr_resolver_chk
  import pgr_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic [PORT_W-1:0]     src_port_i,
  input logic                  hit_i,
  input logic [TYPE_W-1:0]     hit_type_i,
  input logic                  dst_cpu_w,
  input logic                  res_valid_o,
  input logic [NUM_FRONT-1:0]  fwd_mask_o,
  input logic                  cpu_copy_o,
  input logic [Q_W-1:0]        cpu_queue_o
);
  AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o); // R2

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o); // R2

  AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (fwd_mask_o == '0 && !cpu_copy_o && cpu_queue_o == '0)); // R2

  AST_NO_SELF_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && src_port_i < PORT_W'(NUM_FRONT)) |=>
      ((fwd_mask_o & (NUM_FRONT'(1) << $past(src_port_i))) == '0)); // R6

  AST_HIT_CPU_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && hit_i && hit_type_i < TYPE_W'(2) && dst_cpu_w) |=> cpu_copy_o); // R7

  AST_QUEUE_ONLY_WITH_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_copy_o |-> cpu_queue_o == '0); // R9

  AST_BAD_PORT_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && src_port_i >= PORT_W'(NUM_FRONT)) |=> fwd_mask_o == '0); // R12
endmodule

bind pgr_resolver pgr_resolver_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .src_port_i  (src_port_i),
  .hit_i       (hit_i),
  .hit_type_i  (hit_type_i),
  .dst_cpu_w   (dst_cpu_w),
  .res_valid_o (res_valid_o),
  .fwd_mask_o  (fwd_mask_o),
  .cpu_copy_o  (cpu_copy_o),
  .cpu_queue_o (cpu_queue_o)
);

// File: tb/sim_pgr_resolver.sv
module sim_pgr_resolver;
  import pgr_pkg::*;
  localparam int CLK_NS = 10;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 wr_en_i = 1'b0;
  logic [IDX_W-1:0]     wr_idx_i = '0;
  logic [MASK_W-1:0]    wr_mask_i = '0;
  logic [Q_W-1:0]       wr_queue_i = '0;
  logic                 req_valid_i = 1'b0;
  logic [PORT_W-1:0]    src_port_i = '0;
  logic                 hit_i = 1'b0;
  logic [TYPE_W-1:0]    hit_type_i = '0;
  logic [DST_IDX_W-1:0] hit_idx_i = '0;
  logic [1:0]           frame_cls_i = '0;
  logic                 res_valid_o;
  logic [NUM_FRONT-1:0] fwd_mask_o;
  logic                 cpu_copy_o;
  logic [Q_W-1:0]       cpu_queue_o;

  pgr_resolver u0 (.*);

  always #(CLK_NS/2) clk_i = ~clk_i;

  int m_mask [128];
  int m_q    [128];
  int total = 0;
  int bad = 0;
  int e_valid = 0, e_fwd = 0, e_cpu = 0, e_q = 0;
  string e_tag = "R1";

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int v, int port, int hit, int typ, int idx, int cls,
                     int we, int widx, int wmask, int wq, string tag);
    int d, dm, sm, all, f, cpu;
    @(negedge clk_i);
    chk("R2 valid", int'(res_valid_o), e_valid);
    chk({e_tag, " fwd"}, int'(fwd_mask_o), e_fwd);
    chk({e_tag, " cpu"}, int'(cpu_copy_o), e_cpu);
    chk("R9 queue", int'(cpu_queue_o), e_q);
    req_valid_i = v[0];
    src_port_i  = PORT_W'(port);
    hit_i       = hit[0];
    hit_type_i  = TYPE_W'(typ);
    hit_idx_i   = DST_IDX_W'(idx);
    frame_cls_i = 2'(cls);
    wr_en_i     = we[0];
    wr_idx_i    = IDX_W'(widx);
    wr_mask_i   = MASK_W'(wmask);
    wr_queue_i  = Q_W'(wq);
    e_tag = tag;
    if (v == 0) begin
      e_valid = 0; e_fwd = 0; e_cpu = 0; e_q = 0;
    end else begin
      if (hit != 0) d = idx;
      else if (cls == 0) d = 60;
      else if (cls == 1) d = 61;
      else d = 62;
      dm  = m_mask[d];
      sm  = (port < 12) ? m_mask[80 + port] : 0;
      all = dm & sm;
      f   = all & 'hFFF;
      if (port < 12) f = f & ~(1 << port);
      cpu = ((all >> 12) & 1) | ((hit != 0 && typ < 2) ? ((dm >> 12) & 1) : 0);
      e_valid = 1; e_fwd = f; e_cpu = cpu; e_q = (cpu != 0) ? m_q[d] : 0;
    end
    if (we != 0 && widx < 96) begin
      if (widx == 59) m_q[59] = wq;
      else begin m_mask[widx] = wmask; m_q[widx] = wq; end
    end
  endtask

  task automatic wr(int idx, int mask, int q);
    cyc(0, 0, 0, 0, 0, 0, 1, idx, mask, q, "R2");
  endtask

  task automatic lk(int port, int hit, int typ, int idx, int cls, string tag);
    cyc(1, port, hit, typ, idx, cls, 0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_NS * 50000);
    total++; bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      m_mask[i] = (i < 12) ? (1 << i) : ((i == 59) ? (1 << 12) : 0);
      m_q[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    // R1: reset state at the ports
    chk("R1 valid", int'(res_valid_o), 0);
    chk("R1 fwd", int'(fwd_mask_o), 0);
    chk("R1 cpu", int'(cpu_copy_o), 0);
    rst_ni = 1'b1;
    // R1: default table contents seen through lookups
    lk(0, 1, 0, 59, 0, "R1");
    lk(2, 1, 0, 5, 0, "R1");
    // R5: open source masks for every port, CPU excluded
    for (int p = 0; p < 12; p++) wr(80 + p, 'h0FFF, 0);
    // R3 / R6: unicast hits from several ports
    for (int p = 0; p < 12; p++) lk(p, 1, 0, (p * 5) % 12, 0, "R3");
    lk(7, 1, 1, 7, 0, "R6");
    // R7 / R8: multicast entry naming the CPU, queue 5
    wr(20, 'h10A5, 5);
    lk(1, 1, 0, 20, 0, "R7");
    lk(1, 1, 1, 20, 0, "R7");
    lk(1, 1, 2, 20, 0, "R8");
    lk(1, 1, 3, 20, 0, "R8");
    // R4: flood entries by class
    wr(60, 'h1F0F, 1);
    wr(61, 'h1FF0, 2);
    wr(62, 'h1FFF, 3);
    for (int c = 0; c < 4; c++) lk(9, 0, 0, 20, c, "R4");
    // R8: flooded frame reaches CPU only when the source mask allows it
    wr(83, 'h1FFF, 0);
    for (int c = 0; c < 4; c++) lk(3, 0, 0, 0, c, "R8");
    lk(3, 1, 2, 20, 0, "R8");
    // R5: restrictive source mask
    wr(84, 'h0003, 0);
    lk(4, 0, 0, 0, 2, "R5");
    lk(4, 1, 0, 20, 0, "R5");
    // R10: entry 59 mask locked, queue writable
    wr(59, 'h0FFF, 6);
    lk(0, 1, 0, 59, 0, "R10");
    lk(0, 1, 2, 59, 0, "R10");
    // R11: write and lookup in the same cycle
    cyc(1, 5, 1, 0, 20, 0, 1, 20, 'h0F00, 4, "R11");
    lk(5, 1, 0, 20, 0, "R11");
    // R12: out-of-range ingress ports
    lk(12, 1, 0, 20, 0, "R12");
    lk(15, 1, 0, 59, 0, "R12");
    lk(13, 0, 0, 0, 2, "R12");
    // R3: mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      int v, we, widx, pick;
      v  = int'($urandom_range(0, 3) != 0);
      we = int'($urandom_range(0, 3) == 0);
      pick = $urandom_range(0, 3);
      if (pick == 0) widx = 80 + $urandom_range(0, 11);
      else if (pick == 1) widx = 59 + $urandom_range(0, 3);
      else if (pick == 2) widx = $urandom_range(0, 63);
      else widx = $urandom_range(0, 127);
      cyc(v, $urandom_range(0, 13), $urandom_range(0, 1), $urandom_range(0, 3),
          $urandom_range(0, 63), $urandom_range(0, 3), we, widx,
          $urandom_range(0, 'h1FFF), $urandom_range(0, 7), "R3");
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    summary();
    $finish;
  end
endmodule